// File: doc/BRIEF.md
# Cartridge ROM Bank Controller

This block sits between a CPU and a cartridge ROM. From the cartridge type byte it picks a mapper personality. It then watches CPU writes that land in the ROM address window and keeps a switchable ROM bank number up to date. Each personality has its own rule for turning the written data into a bank number.

Reads in the upper half of the ROM window (0x4000–0x7FFF) go to the switchable bank. Reads in the lower half (0x0000–0x3FFF) always go to bank 0. The block outputs the current bank and a physical ROM address. The ROM size, given as a count of 16 KiB banks, is an input. Any request for a bank that the ROM does not hold is dropped, and the previous bank stays in place.

The personality is decoded from the type byte without a register, so it follows that input from one cycle to the next. Writes that would reach RAM enable, external RAM banking, clock or mode registers are accepted and change nothing.

Top module: `rom_bank_mapper`

## Requirements
- R1: While reset is held, and after it is released, `cur_bank` is 1 until a valid bank-select write occurs.
- R2: With type byte 0x00, 0x08 or 0x09 (no mapper), no write changes `cur_bank`.
- R3: With type byte 0x05, 0x06, 0x15, 0x16 or 0x17, no write changes `cur_bank`.
- R4: Only a write with `wr_addr[15:13]` = 3'b001 (0x2000–0x3FFF) can change the bank. Writes to 0x0000–0x1FFF, to 0x4000–0x7FFF and above 0x7FFF leave `cur_bank` unchanged.
- R5: With type 0x01–0x03, the requested bank takes `wr_data[4:0]` as its low five bits, with 0 replaced by 1. Bits 5 and above of the current bank are kept.
- R6: With type 0x0F–0x13, the requested bank is `wr_data[6:0]`, with 0 replaced by 1.
- R7: With type 0x19–0x1E, or with any type byte not listed in R2, R3, R5 or R6, the requested bank is `wr_data[6:0]` and bank 0 may be selected.
- R8: A requested bank is applied only when it is less than `rom_banks`. Otherwise `cur_bank` keeps its value.
- R9: `rom_addr` is `{cur_bank, wr_addr[13:0]}` when `wr_addr[14]` is 1. It is `{0, wr_addr[13:0]}` when `wr_addr[14]` is 0. It is combinational in the address.
- R10: An accepted bank-select write shows on `cur_bank` after the clock edge that samples the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cart_type | input | 8 | Cartridge type byte from the ROM header |
| rom_banks | input | BANK_W+1 | Number of 16 KiB banks in the ROM |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | 16 | CPU address, used for both writes and reads |
| wr_data | input | 8 | CPU write data |
| cur_bank | output | BANK_W | Current switchable bank |
| rom_addr | output | BANK_W+14 | Physical ROM byte address |

## Verification
The only state is the bank register, so any corruption of it shows on `cur_bank` on the cycle after the write that caused it. It shows on `rom_addr` at once for every upper-window read. A wrong personality decode, a missing zero remap or lost upper bits shows within one write of the type and data pattern involved. A loose range check shows on the first write past the ROM end.

// File: rtl/rom_bank_mapper.sv
module rom_bank_mapper #(
  parameter int BANK_W = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [7:0]           cart_type,
  input  logic [BANK_W:0]      rom_banks,
  input  logic                 wr_en,
  input  logic [15:0]          wr_addr,
  input  logic [7:0]           wr_data,
  output logic [BANK_W-1:0]    cur_bank,
  output logic [BANK_W+13:0]   rom_addr
);

  localparam logic [BANK_W-1:0] LOW5_MASK = BANK_W'(5'h1F);
  localparam logic [BANK_W-1:0] ONE       = BANK_W'(1);

  typedef enum logic [2:0] {K_NONE, K_A, K_B, K_C, K_D, K_E} kind_t;

  kind_t            kind;
  logic             sel_hit;
  logic [BANK_W-1:0] fld5, fld7, req;
  logic             req_ok;

  always_comb begin
    case (cart_type)
      8'h00, 8'h08, 8'h09:                    kind = K_NONE;
      8'h01, 8'h02, 8'h03:                    kind = K_A;
      8'h05, 8'h06:                           kind = K_B;
      8'h0F, 8'h10, 8'h11, 8'h12, 8'h13:      kind = K_C;
      8'h15, 8'h16, 8'h17:                    kind = K_D;
      default:                                kind = K_E;
    endcase
  end

  assign sel_hit = wr_en && (wr_addr[15:13] == 3'b001);
  assign fld5    = BANK_W'(wr_data[4:0]);
  assign fld7    = BANK_W'(wr_data[6:0]);

  always_comb begin
    case (kind)
      K_A:     req = (cur_bank & ~LOW5_MASK) | ((fld5 == '0) ? ONE : fld5);
      K_C:     req = (fld7 == '0) ? ONE : fld7;
      K_E:     req = fld7;
      default: req = cur_bank;
    endcase
  end

  assign req_ok = ({1'b0, req} < rom_banks) &&
                  (kind == K_A || kind == K_C || kind == K_E);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cur_bank <= ONE;
    else if (sel_hit && req_ok)
      cur_bank <= req;
  end

  assign rom_addr = {(wr_addr[14] ? cur_bank : '0), wr_addr[13:0]};

endmodule

// File: rtl/rom_bank_mapper_chk.sv
module rom_bank_mapper_chk #(
  parameter int BANK_W = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic [7:0]         cart_type,
  input logic [BANK_W:0]    rom_banks,
  input logic               wr_en,
  input logic [15:0]        wr_addr,
  input logic [BANK_W-1:0]  cur_bank,
  input logic [BANK_W+13:0] rom_addr
);

  logic frozen_type;
  assign frozen_type = (cart_type == 8'h00) || (cart_type == 8'h08) || (cart_type == 8'h09) ||
                       (cart_type == 8'h05) || (cart_type == 8'h06) ||
                       (cart_type == 8'h15) || (cart_type == 8'h16) || (cart_type == 8'h17);

  p_reset_bank_r1: assert property (@(posedge clk) !rst_n |=> cur_bank == BANK_W'(1));

  p_frozen_types_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frozen_type |=> $stable(cur_bank));  // covers R3 as well

  p_only_select_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr[15:13] == 3'b001) |=> $stable(cur_bank));

  p_bank_in_rom_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_bank != $past(cur_bank)) |-> ({1'b0, cur_bank} < $past(rom_banks)));

  p_low_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_addr[14] |-> (rom_addr[BANK_W+13:14] == '0 && rom_addr[13:0] == wr_addr[13:0]));

  p_high_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_addr[14] |-> (rom_addr[BANK_W+13:14] == cur_bank && rom_addr[13:0] == wr_addr[13:0]));

endmodule

bind rom_bank_mapper rom_bank_mapper_chk #(.BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cart_type(cart_type), .rom_banks(rom_banks),
  .wr_en(wr_en), .wr_addr(wr_addr), .cur_bank(cur_bank), .rom_addr(rom_addr)
);

// File: tb/sim_rom_bank_mapper.sv
module sim_rom_bank_mapper;
  localparam int CLK_PERIOD = 10;
  localparam int BANK_W = 7;

  logic              clk = 0;
  logic              rst_n = 0;
  logic [7:0]        cart_type = 8'h00;
  logic [BANK_W:0]   rom_banks = 8'd128;
  logic              wr_en = 0;
  logic [15:0]       wr_addr = 16'h0000;
  logic [7:0]        wr_data = 8'h00;
  logic [BANK_W-1:0] cur_bank;
  logic [BANK_W+13:0] rom_addr;

  int checks = 0, fails = 0;
  logic [BANK_W-1:0] exp_bank;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rom_bank_mapper #(.BANK_W(BANK_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cart_type(cart_type), .rom_banks(rom_banks),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cur_bank(cur_bank), .rom_addr(rom_addr));

  // 0 none, 1 A, 2 B, 3 C, 4 D, 5 E
  function automatic int kind_of(input logic [7:0] t);
    if (t == 8'h00 || t == 8'h08 || t == 8'h09) return 0;
    if (t >= 8'h01 && t <= 8'h03) return 1;
    if (t == 8'h05 || t == 8'h06) return 2;
    if (t >= 8'h0F && t <= 8'h13) return 3;
    if (t >= 8'h15 && t <= 8'h17) return 4;
    return 5;
  endfunction

  function automatic logic [BANK_W-1:0] model(input logic [7:0] t, input logic [15:0] a,
      input logic [7:0] d, input logic [BANK_W:0] n, input logic [BANK_W-1:0] cur);
    int k = kind_of(t);
    int r;
    if (a[15:13] != 3'b001) return cur;
    case (k)
      1: begin r = (d[4:0] == 0) ? 1 : int'(d[4:0]); r = r | (int'(cur) & ~32'h1F); end
      3: r = (d[6:0] == 0) ? 1 : int'(d[6:0]);
      5: r = int'(d[6:0]);
      default: return cur;
    endcase
    if (r < int'(n)) return BANK_W'(r);
    return cur;
  endfunction

  task automatic check_bank(input string tag);
    checks++;
    if (cur_bank !== exp_bank) begin
      fails++;
      $display("FAIL %s: cur_bank=%0h expected %0h", tag, cur_bank, exp_bank);
    end
  endtask

  task automatic check_addr(input string tag);
    logic [BANK_W+13:0] e;
    e = {(wr_addr[14] ? exp_bank : '0), wr_addr[13:0]};
    checks++;
    if (rom_addr !== e) begin
      fails++;
      $display("FAIL %s: rom_addr=%0h expected %0h", tag, rom_addr, e);
    end
  endtask

  task automatic wr(input logic [7:0] t, input logic [15:0] a, input logic [7:0] d, input string tag);
    @(negedge clk);
    cart_type = t; wr_addr = a; wr_data = d; wr_en = 1;
    exp_bank = model(t, a, d, rom_banks, exp_bank);
    @(negedge clk);
    wr_en = 0;
    check_bank(tag);  // R10: visible one edge after the write
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    exp_bank = 1;
    repeat (3) @(negedge clk);
    check_bank("R1 during reset");
    rst_n = 1;
    @(negedge clk);
    check_bank("R1 after reset");

    // R6 / R10
    wr(8'h13, 16'h2000, 8'hC5, "R6 low7");
    wr(8'h0F, 16'h3FFF, 8'h80, "R6 zero->1");
    wr(8'h13, 16'h2100, 8'h45, "R6 set 0x45");
    // R5
    wr(8'h01, 16'h2000, 8'h00, "R5 zero->1 keep upper");
    wr(8'h03, 16'h2000, 8'hFF, "R5 low5 keep upper");
    // R7
    wr(8'h19, 16'h2000, 8'h00, "R7 bank0");
    wr(8'hFF, 16'h2000, 8'h83, "R7 fallback");
    wr(8'h1E, 16'h2000, 8'h7F, "R7 max");
    // R4
    wr(8'h19, 16'h1000, 8'h05, "R4 low range");
    wr(8'h19, 16'h4000, 8'h05, "R4 upper window");
    wr(8'h19, 16'hA000, 8'h05, "R4 outside ROM");
    // R2 / R3
    wr(8'h00, 16'h2000, 8'h05, "R2 none 0x00");
    wr(8'h09, 16'h2000, 8'h06, "R2 none 0x09");
    wr(8'h06, 16'h2000, 8'h07, "R3 type 0x06");
    wr(8'h16, 16'h2000, 8'h08, "R3 type 0x16");
    // R8
    @(negedge clk); rom_banks = 4;
    wr(8'h19, 16'h2000, 8'h03, "R8 last bank");
    wr(8'h19, 16'h2000, 8'h04, "R8 beyond end");
    wr(8'h11, 16'h2000, 8'h10, "R8 beyond end C");
    // R9
    @(negedge clk); wr_addr = 16'h7ABC; #1 check_addr("R9 high window");
    wr_addr = 16'h3ABC; #1 check_addr("R9 low window");

    for (int i = 0; i < 400; i++) begin
      logic [7:0] t; logic [15:0] a;
      case ($urandom % 6)
        0: t = 8'h02; 1: t = 8'h10; 2: t = 8'h1B; 3: t = 8'h05;
        4: t = 8'h08; default: t = 8'($urandom);
      endcase
      a = ($urandom % 3 != 0) ? (16'h2000 | 16'($urandom % 16'h2000)) : 16'($urandom);
      if ($urandom % 8 == 0) begin
        @(negedge clk);
        case ($urandom % 4) 0: rom_banks = 2; 1: rom_banks = 32; 2: rom_banks = 100; default: rom_banks = 128; endcase
      end
      wr(t, a, 8'($urandom), "R5-R8 random");
      wr_addr = 16'($urandom); #1 check_addr("R9 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule